// File: doc/BRIEF.md
# Dual-Channel Sticky Fault Status Unit

This block watches two output channels for two kinds of trouble: loss of the reference input and loss of phase lock between the reference and the generated output. The signal path supplies one raw fault level per channel and per fault type. Any cycle in which that level is high on a monitored channel sets a sticky status bit. The bit stays set until software reads the status register that holds it. Monitoring is always running and cannot be switched off. A channel that software has not marked as monitored always reports zero, so unused channels raise no false alarms.

A small synchronous register bus gives access to four 16-bit registers. The monitored-channel mask sits at address 0. Sticky reference-loss status sits at address 1. Sticky phase-lock-loss status sits at address 2. The per-channel reference-loss interrupt enable sits at address 3. In every register, bit 0 belongs to channel 1 and bit 1 belongs to channel 2. The interrupt output is high while any enabled channel has its reference-loss bit set.

Each channel and fault type also has a monitor state machine with three states:
- `MON_OK`: no fault.
- `MON_WAIT`: a fault is present and ticks are being counted.
- `MON_HOLD`: the fault has been sustained.

The transitions are:
- ok-to-wait, when a fault appears on a monitored channel.
- wait-to-ok and hold-to-ok, when the fault goes away or the channel is unmonitored.
- wait-to-hold, when the tick count expires.

A tick divider sets the tick period. By default, 50 000 cycles make one tick and 2 000 ticks give the limit, which is two seconds at 50 MHz.

Top module: `fault_status_unit`

## Requirements
- R1: Register addresses are 0 = monitored mask, 1 = reference-loss status, 2 = phase-lock-loss status, 3 = interrupt enable. Bit 0 is channel 1 and bit 1 is channel 2. Bits 15..2 always read 0. Read data appears on `bus_rdata` on the clock edge at which `bus_rd` is sampled, and it holds until the next read.
- R2: The monitored mask resets to 0 and reads back the value written to its two low bits. A mask bit of 1 means the channel is monitored.
- R3: A channel whose mask bit is 0 reads 0 in both status registers and never shows a sustained flag, whatever its raw fault input does.
- R4: A raw fault on a monitored channel that lasts even a single cycle sets that channel's status bit, and the bit stays set after the fault goes away.
- R5: A read of a status register returns the latched bits and then clears them. The other status register is not affected.
- R6: If a raw fault is still present in the cycle of a clearing read, the status bit remains set.
- R7: Writes to the two status addresses have no effect.
- R8: The interrupt enable resets to 0, and `irq` stays low while no enable bit is set.
- R9: `irq` is high exactly when some channel has both its enable bit and its reference-loss status bit set. Phase-lock-loss status never drives `irq`.
- R10: A sustained flag rises after its fault has been continuously present on a monitored channel for more than (HOLD_TICKS-1)*TICK_DIV cycles and at most HOLD_TICKS*TICK_DIV cycles. It falls on the first edge after the fault disappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_loss_raw | input | NCH | Raw reference-loss level per channel |
| lock_loss_raw | input | NCH | Raw phase-lock-loss level per channel |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears status at addresses 1 and 2 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Reference-loss interrupt |
| ref_sustained | output | NCH | Reference loss sustained past the tick limit |
| lock_sustained | output | NCH | Phase-lock loss sustained past the tick limit |

## Verification
A sticky bit that is lost or stuck shows up on the next status read as a wrong bit. A bit that should have been cleared shows up on the read after that. Either way the fault is visible within two bus operations. A broken mask makes an inactive channel read 1, or drives `irq` one cycle after the raw input rises. A wrong monitor state or wrong tick count moves the rising edge of the sustained flag outside its window of one tick period. The bench therefore samples that flag just before the window opens and just after it closes.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
    localparam int DATA_W = 16;

    localparam logic [1:0] ADDR_ACTIVE = 2'd0;
    localparam logic [1:0] ADDR_REF    = 2'd1;
    localparam logic [1:0] ADDR_LOCK   = 2'd2;
    localparam logic [1:0] ADDR_IRQEN  = 2'd3;

    typedef enum logic [1:0] {
        MON_OK   = 2'd0,
        MON_WAIT = 2'd1,
        MON_HOLD = 2'd2
    } mon_state_t;
endpackage

// File: rtl/fsu_tick.sv
module fsu_tick #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || cnt_q == LAST) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/fsu_monitor.sv
module fsu_monitor
    import fsu_pkg::*;
#(
    parameter int HOLD_TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic raw,
    input  logic tick,
    input  logic clr,
    output logic stat,
    output logic sustained
);
    localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    mon_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          fault;

    assign fault = raw & act;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MON_OK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_OK:   if (fault) state_d = MON_WAIT;
            MON_WAIT: begin
                if (!fault)                   state_d = MON_OK;
                else if (tick && cnt_q == LAST) state_d = MON_HOLD;
            end
            MON_HOLD: if (!fault) state_d = MON_OK;
            default:  state_d = MON_OK;
        endcase
    end

    // tick counter while waiting
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != MON_WAIT) cnt_q <= '0;
        else if (tick && cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
    end

    // sticky status, cleared on read or when unmonitored
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= 1'b0;
        else        stat <= act & ((stat & ~clr) | raw);
    end

    // outputs
    always_comb begin
        sustained = (state_q == MON_HOLD);
    end

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && act && !clr) |=> stat);
    // R4
    fault_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && act) |=> stat);
    // R3
    inactive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (!stat && !sustained));
    // R10
    hold_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sustained) |-> $past(state_q == MON_WAIT && fault && tick));
    // R6
    clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && raw && act) |=> stat);
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
    import fsu_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int TICK_DIV   = 50000,
    parameter int HOLD_TICKS = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ref_loss_raw,
    input  logic [NCH-1:0]    lock_loss_raw,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [NCH-1:0]    ref_sustained,
    output logic [NCH-1:0]    lock_sustained
);
    localparam int PAD = DATA_W - NCH;

    logic [NCH-1:0] active_q, irq_en_q, ref_stat, lock_stat;
    logic [NCH-1:0] rd_view;
    logic           tick, clr_ref, clr_lock;
    logic           unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:NCH];

    fsu_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    assign clr_ref  = bus_rd && (bus_addr == ADDR_REF);
    assign clr_lock = bus_rd && (bus_addr == ADDR_LOCK);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        fsu_monitor #(.HOLD_TICKS(HOLD_TICKS)) u_ref (
            .clk(clk), .rst_n(rst_n), .act(active_q[ch]),
            .raw(ref_loss_raw[ch]), .tick(tick), .clr(clr_ref),
            .stat(ref_stat[ch]), .sustained(ref_sustained[ch])
        );
        fsu_monitor #(.HOLD_TICKS(HOLD_TICKS)) u_lock (
            .clk(clk), .rst_n(rst_n), .act(active_q[ch]),
            .raw(lock_loss_raw[ch]), .tick(tick), .clr(clr_lock),
            .stat(lock_stat[ch]), .sustained(lock_sustained[ch])
        );
    end

    // control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            irq_en_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_ACTIVE) active_q <= bus_wdata[NCH-1:0];
            if (bus_addr == ADDR_IRQEN)  irq_en_q <= bus_wdata[NCH-1:0];
        end
    end

    always_comb begin
        rd_view = '0;
        unique case (bus_addr)
            ADDR_ACTIVE: rd_view = active_q;
            ADDR_REF:    rd_view = ref_stat & active_q;
            ADDR_LOCK:   rd_view = lock_stat & active_q;
            ADDR_IRQEN:  rd_view = irq_en_q;
            default:     rd_view = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= {{PAD{1'b0}}, rd_view};
    end

    assign irq = |(ref_stat & active_q & irq_en_q);

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en_q != '0));
    // R9
    irq_from_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((ref_stat & active_q) != '0));
    // R1
    rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NCH] == '0);
    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/fault_status_unit_tb.sv
`timescale 1ns/1ps
module fault_status_unit_tb;
    localparam int NCH = 2;
    localparam int DIV = 4;
    localparam int HT  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ref_raw = '0, lock_raw = '0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic [1:0]  ref_sus, lock_sus;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fault_status_unit #(.NCH(NCH), .TICK_DIV(DIV), .HOLD_TICKS(HT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_loss_raw(ref_raw), .lock_loss_raw(lock_raw),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .ref_sustained(ref_sus), .lock_sustained(lock_sus)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
        logic [15:0] d;
        rd(a, d);
        check(d === exp, req, d, exp);
    endtask

    task automatic test_reset();
        check(bus_rdata === 16'h0, "R1 rdata after reset", bus_rdata, 16'h0);
        check(irq === 1'b0, "R8 irq after reset", {15'h0, irq}, 16'h0);
        rd_chk(2'd0, 16'h0, "R2 mask reset");
        rd_chk(2'd3, 16'h0, "R8 enable reset");
        rd_chk(2'd1, 16'h0, "R1 ref status reset");
    endtask

    task automatic test_mask();
        wr(2'd0, 16'hFFFF);
        rd_chk(2'd0, 16'h0003, "R1 unused bits read zero");
        wr(2'd0, 16'h0001);
        rd_chk(2'd0, 16'h0001, "R2 mask readback");
    endtask

    task automatic test_inactive();
        wr(2'd0, 16'h0000);
        @(negedge clk); ref_raw = 2'b11; lock_raw = 2'b11;
        repeat (30) @(negedge clk);
        check(ref_sus === 2'b00 && lock_sus === 2'b00, "R3 no sustain inactive",
              {12'h0, ref_sus, lock_sus}, 16'h0);
        rd_chk(2'd1, 16'h0, "R3 ref inactive");
        rd_chk(2'd2, 16'h0, "R3 lock inactive");
        ref_raw = 2'b00; lock_raw = 2'b00;
        wr(2'd0, 16'h0003);
        @(negedge clk); ref_raw = 2'b01;
        @(negedge clk); ref_raw = 2'b00;
        wr(2'd0, 16'h0002);
        rd_chk(2'd1, 16'h0, "R3 latched then deactivated");
        wr(2'd0, 16'h0003);
        rd_chk(2'd1, 16'h0, "R3 reactivated reads clear");
    endtask

    task automatic test_sticky();
        @(negedge clk); ref_raw = 2'b10;
        @(negedge clk); ref_raw = 2'b00;
        repeat (5) @(negedge clk);
        rd_chk(2'd1, 16'h0002, "R4 one-cycle pulse latched");
        rd_chk(2'd1, 16'h0000, "R5 cleared by read");
        @(negedge clk); ref_raw = 2'b01; lock_raw = 2'b01;
        @(negedge clk); ref_raw = 2'b00; lock_raw = 2'b00;
        rd_chk(2'd1, 16'h0001, "R4 ref ch1 latched");
        rd_chk(2'd2, 16'h0001, "R5 lock kept after ref read");
        rd_chk(2'd2, 16'h0000, "R5 lock cleared");
    endtask

    task automatic test_read_race();
        @(negedge clk); ref_raw = 2'b01;
        rd_chk(2'd1, 16'h0001, "R6 first read");
        rd_chk(2'd1, 16'h0001, "R6 kept while fault present");
        ref_raw = 2'b00;
        rd_chk(2'd1, 16'h0001, "R6 set across clearing read");
        rd_chk(2'd1, 16'h0000, "R5 cleared after fault gone");
    endtask

    task automatic test_status_write();
        @(negedge clk); ref_raw = 2'b01;
        @(negedge clk); ref_raw = 2'b00;
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0003);
        rd_chk(2'd1, 16'h0001, "R7 ref write ignored");
        rd_chk(2'd2, 16'h0000, "R7 lock write ignored");
    endtask

    task automatic test_irq();
        @(negedge clk); ref_raw = 2'b10;
        @(negedge clk); ref_raw = 2'b00;
        check(irq === 1'b0, "R8 irq low without enable", {15'h0, irq}, 16'h0);
        wr(2'd3, 16'h0001);
        check(irq === 1'b0, "R9 other channel enabled", {15'h0, irq}, 16'h0);
        wr(2'd3, 16'h0002);
        check(irq === 1'b1, "R9 irq high", {15'h0, irq}, 16'h1);
        rd_chk(2'd1, 16'h0002, "R9 ref status");
        check(irq === 1'b0, "R9 irq drops after clear", {15'h0, irq}, 16'h0);
        @(negedge clk); lock_raw = 2'b10;
        @(negedge clk); lock_raw = 2'b00;
        @(negedge clk);
        check(irq === 1'b0, "R9 lock loss no irq", {15'h0, irq}, 16'h0);
        rd_chk(2'd2, 16'h0002, "R9 lock latched");
        wr(2'd3, 16'h0000);
    endtask

    task automatic test_sustain();
        @(negedge clk); lock_raw = 2'b01;
        repeat ((HT - 1) * DIV + 1) @(posedge clk);
        #5;
        check(lock_sus === 2'b00, "R10 not before window", {14'h0, lock_sus}, 16'h0);
        repeat (DIV) @(posedge clk);
        #5;
        check(lock_sus === 2'b01, "R10 set by window end", {14'h0, lock_sus}, 16'h1);
        check(ref_sus === 2'b00, "R10 other type quiet", {14'h0, ref_sus}, 16'h0);
        @(negedge clk); lock_raw = 2'b00;
        @(negedge clk);
        check(lock_sus === 2'b00, "R10 drops after fault", {14'h0, lock_sus}, 16'h0);
        rd_chk(2'd2, 16'h0001, "R4 sustained fault latched");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_mask();
        wr(2'd0, 16'h0003);
        test_inactive();
        test_sticky();
        test_read_race();
        test_status_write();
        test_irq();
        test_sustain();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 16'h1, 16'h0);
        finish_run();
    end
endmodule